// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block sits between a display controller's timing generator and the panel pins. It decides when the interface signals and the panel supply may leave their idle LOW state. Software writes two control bits. The enable bit lets the control group through: line clock, pixel clock, frame clock, AC bias and line end. The power bit raises the panel power output and lets the pixel data bus through. The block never lets the second group be active unless the first is active too. When the bits are cleared, the groups are shut off in the reverse order.

An internal stage register holds one of three stages: off, control-active or fully-powered. It moves at most one stage per clock, so any change in the bits walks through the stages in order. Any delay the panel needs between the two stages is left to software, which waits before it sets the power bit. Every gated output comes from a flop, so enabling or disabling a group never produces a short pulse on the clocks. The current stage can be read back from the status output.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, every gated output, the data bus and the panel power output are LOW, and the stage reads 0 (off).
- R2: With the enable bit at 1, the stage moves from off (0) to control-active (1) at the next edge. From the edge after that, the five control outputs follow their raw inputs.
- R3: In control-active (1) the data bus is driven all zero and panel power is LOW, whatever the raw data is.
- R4: In control-active with both bits at 1, the stage moves to fully-powered (2). From the edge after that, panel power is HIGH and the data bus follows the raw data.
- R5: With the power bit at 1 and the enable bit at 0, the stage stays off and every output stays LOW.
- R6: If both bits are set while the stage is off, the stage spends exactly one cycle in control-active before it reaches fully-powered. It never goes straight from 0 to 2.
- R7: Clearing the power bit in fully-powered, with enable still 1, returns the stage to control-active. Panel power and data drop one edge later, while the control outputs stay active.
- R8: Clearing the enable bit in fully-powered, even with the power bit still 1, first moves to control-active for one cycle and then to off. Panel power and data always drop at least one edge before the control outputs.
- R9: Every output is registered. At each edge, each gated output takes its raw input ANDed with the group's gate for the stage held before that edge. The stage code is never 3.
- R10: Clearing the enable bit in control-active returns the stage to off. The control outputs drop one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the timing generator |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Software enable bit for the control group |
| pwr_req | input | 1 | Software power bit for panel supply and data |
| line_clk_i | input | 1 | Raw line clock |
| pix_clk_i | input | 1 | Raw pixel clock |
| frame_clk_i | input | 1 | Raw frame clock |
| ac_bias_i | input | 1 | Raw AC bias |
| line_end_i | input | 1 | Raw line end |
| data_i | input | DATA_W (24) | Raw pixel data |
| line_clk_o | output | 1 | Gated line clock |
| pix_clk_o | output | 1 | Gated pixel clock |
| frame_clk_o | output | 1 | Gated frame clock |
| ac_bias_o | output | 1 | Gated AC bias |
| line_end_o | output | 1 | Gated line end |
| data_o | output | DATA_W (24) | Gated pixel data |
| panel_pwr_o | output | 1 | Panel power control |
| stage_o | output | 2 | Stage status: 0 off, 1 control-active, 2 fully-powered |

## Verification
The bench builds the block with its default DATA_W of 24. With that width, the all-ones and random data patterns show any data line that leaks through while the data gate is shut. A fixed-seed random run toggles the two bits so that every ordered transition is covered, including both bits changing at once. The run also reaches the cases where the enable bit drops while the power bit is still set.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    typedef enum logic [1:0] {
        STG_OFF  = 2'd0,
        STG_CTRL = 2'd1,
        STG_FULL = 2'd2
    } stage_e;

    typedef struct packed {
        logic line_clk;
        logic pix_clk;
        logic frame_clk;
        logic ac_bias;
        logic line_end;
    } ctl_sig_t;

    localparam int CTL_W = $bits(ctl_sig_t);

    // Move at most one stage per cycle toward the stage the bits ask for.
    function automatic stage_e step_stage(stage_e cur, logic en, logic pwr);
        stage_e nxt;
        unique case (cur)
            STG_OFF:  nxt = en ? STG_CTRL : STG_OFF;
            STG_CTRL: nxt = !en ? STG_OFF : (pwr ? STG_FULL : STG_CTRL);
            STG_FULL: nxt = (en && pwr) ? STG_FULL : STG_CTRL;
            default:  nxt = STG_OFF;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lcdseq_stage_fsm.sv
module lcdseq_stage_fsm
    import lcdseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   pwr,
    output stage_e stage_q
);

    always_ff @(posedge clk) begin
        if (rst) stage_q <= STG_OFF;
        else     stage_q <= step_stage(stage_q, en, pwr);
    end

    p_no_skip_up_r6: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_OFF) |=> (stage_q != STG_FULL));

    p_no_skip_down_r8: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_FULL) |=> (stage_q != STG_OFF));

    p_en_drop_full_r8: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_FULL && !en) |=> (stage_q == STG_CTRL));

    p_pwr_alone_off_r5: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_OFF && !en) |=> (stage_q == STG_OFF));

    p_legal_code_r9: assert property (@(posedge clk) disable iff (rst)
        (stage_q != 2'd3));

endmodule

// File: rtl/lcdseq_gate.sv
module lcdseq_gate #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) dout[i] <= 1'b0;
            else     dout[i] <= din[i] & open;
        end
    end

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcdseq_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_en,
    input  logic              pwr_req,
    input  logic              line_clk_i,
    input  logic              pix_clk_i,
    input  logic              frame_clk_i,
    input  logic              ac_bias_i,
    input  logic              line_end_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              line_clk_o,
    output logic              pix_clk_o,
    output logic              frame_clk_o,
    output logic              ac_bias_o,
    output logic              line_end_o,
    output logic [DATA_W-1:0] data_o,
    output logic              panel_pwr_o,
    output logic [1:0]        stage_o
);

    stage_e   stage_q;
    ctl_sig_t ctl_raw, ctl_gated;
    logic     ctl_open, data_open;

    lcdseq_stage_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (ctl_en),
        .pwr     (pwr_req),
        .stage_q (stage_q)
    );

    assign ctl_open  = (stage_q != STG_OFF);
    assign data_open = (stage_q == STG_FULL);

    assign ctl_raw = '{line_clk:  line_clk_i,  pix_clk:  pix_clk_i,
                       frame_clk: frame_clk_i, ac_bias:  ac_bias_i,
                       line_end:  line_end_i};

    lcdseq_gate #(.WIDTH(CTL_W)) u_ctl_gate (
        .clk  (clk),
        .rst  (rst),
        .open (ctl_open),
        .din  (ctl_raw),
        .dout (ctl_gated)
    );

    lcdseq_gate #(.WIDTH(DATA_W)) u_data_gate (
        .clk  (clk),
        .rst  (rst),
        .open (data_open),
        .din  (data_i),
        .dout (data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) panel_pwr_o <= 1'b0;
        else     panel_pwr_o <= data_open;
    end

    assign line_clk_o  = ctl_gated.line_clk;
    assign pix_clk_o   = ctl_gated.pix_clk;
    assign frame_clk_o = ctl_gated.frame_clk;
    assign ac_bias_o   = ctl_gated.ac_bias;
    assign line_end_o  = ctl_gated.line_end;
    assign stage_o     = stage_q;

    p_data_needs_power_r4: assert property (@(posedge clk) disable iff (rst)
        (data_o != '0) |-> panel_pwr_o);

    p_power_off_before_ctl_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(panel_pwr_o) |-> ($past(stage_q) == STG_CTRL));

    p_ctl_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_OFF && $past(stage_q) == STG_OFF) |-> (ctl_gated == '0 && !panel_pwr_o));

endmodule

// File: tb/tb_lcd_pwr_seq.sv
`timescale 1ns/1ps
module tb_lcd_pwr_seq;

    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, pw = 1'b0;
    logic [4:0] raw_ctl = '0;
    logic [DW-1:0] raw_data = '0;
    logic lc, pc, fc, ac, le, ppwr;
    logic [DW-1:0] dout;
    logic [1:0] stg;

    int total = 0, bad = 0;
    bit done = 0;
    int mstage = 0;

    always #2.5 clk = ~clk;

    lcd_pwr_seq #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .ctl_en(en), .pwr_req(pw),
        .line_clk_i(raw_ctl[4]), .pix_clk_i(raw_ctl[3]), .frame_clk_i(raw_ctl[2]),
        .ac_bias_i(raw_ctl[1]), .line_end_i(raw_ctl[0]), .data_i(raw_data),
        .line_clk_o(lc), .pix_clk_o(pc), .frame_clk_o(fc), .ac_bias_o(ac),
        .line_end_o(le), .data_o(dout), .panel_pwr_o(ppwr), .stage_o(stg)
    );

    function automatic int model_next(int cur, logic e, logic p);
        case (cur)
            0: return e ? 1 : 0;
            1: return !e ? 0 : (p ? 2 : 1);
            default: return (e && p) ? 2 : 1;
        endcase
    endfunction

    function automatic logic [31:0] model_out(int cur, logic [4:0] c, logic [DW-1:0] d);
        logic [4:0] ec;
        logic [DW-1:0] ed;
        ec = (cur != 0) ? c : 5'b0;
        ed = (cur == 2) ? d : '0;
        return {2'b0, ec, (cur == 2), ed};
    endfunction

    task automatic compare(string tag, logic [31:0] exp_o, int exp_s);
        logic [31:0] got;
        got = {2'b0, lc, pc, fc, ac, le, ppwr, dout};
        total++;
        if (got !== exp_o || stg !== exp_s[1:0]) begin
            bad++;
            $display("FAIL %s: got out=%h stage=%0d, exp out=%h stage=%0d",
                     tag, got, stg, exp_o, exp_s);
        end
    endtask

    task automatic step(string tag, logic e, logic p, logic [4:0] c, logic [DW-1:0] d);
        logic [31:0] exp_o;
        @(negedge clk);
        en = e; pw = p; raw_ctl = c; raw_data = d;
        exp_o = model_out(mstage, c, d);
        mstage = model_next(mstage, e, p);
        @(posedge clk); #1;
        compare(tag, exp_o, mstage);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: got hang, exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] ones;
        ones = '1;
        void'($urandom(32'd1234));
        // R1: reset holds everything low even with bits and raw inputs high
        en = 1'b1; pw = 1'b1; raw_ctl = 5'h1f; raw_data = ones;
        repeat (3) @(posedge clk);
        #1 compare("R1", 32'h0, 0);
        @(negedge clk); rst = 1'b0; en = 1'b0; pw = 1'b0;
        mstage = 0;
        step("R1", 0, 0, 5'h1f, ones);
        // R5: power bit alone does nothing
        step("R5", 0, 1, 5'h1f, ones);
        step("R5", 0, 1, 5'h15, ones);
        // R6 / R2 / R4: both bits from off walk the stages
        step("R6", 1, 1, 5'h1f, ones);
        step("R2", 1, 1, 5'h1b, ones);
        step("R4", 1, 1, 5'h1f, 24'hA5C3F0);
        // R7: drop power only
        step("R7", 1, 0, 5'h1f, ones);
        step("R3", 1, 0, 5'h1f, ones);
        step("R3", 1, 0, 5'h0e, 24'h123456);
        // R10: drop enable from control-active
        step("R10", 0, 0, 5'h1f, ones);
        step("R10", 0, 0, 5'h1f, ones);
        // R8: drop enable while power still set
        step("R2", 1, 0, 5'h1f, ones);
        step("R4", 1, 1, 5'h1f, ones);
        step("R4", 1, 1, 5'h1f, ones);
        step("R8", 0, 1, 5'h1f, ones);
        step("R8", 0, 1, 5'h1f, ones);
        step("R8", 0, 1, 5'h1f, ones);
        // R9: random bit traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic e, p;
            e = ($urandom % 4) != 0;
            p = ($urandom % 3) != 0;
            step("R9", e, p, 5'($urandom), DW'($urandom));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule